// File: doc/BRIEF.md
# CAN Transmit Mailbox Manager

This block holds three outgoing CAN frames between a host and a CAN protocol engine. The host fills a mailbox with an identifier, a frame-format flag (standard or extended), a remote-frame flag, a 4-bit length code and a 64-bit payload. It then sets that mailbox's request bit. The block offers one pending mailbox at a time to the engine through a valid/accept handshake and waits for a single result code. It then posts per-mailbox completion and status flags.

When several mailboxes are pending, the block chooses by identifier priority, as a bus would. A failed or lost attempt is retried unless the one-attempt mode is on. The host can cancel mailboxes with an abort mask, and an interrupt is raised while any mailbox is free and the interrupt enable is set.

Top module: `can_txmb_ctrl`

## Requirements
- R1: After reset all mailboxes are empty, `any_empty` is 1, every completion and status flag is 0, and `eng_req_valid` is 0.
- R2: A write with `wr_en` stores the frame fields into mailbox `wr_sel`, and a `req_set` bit makes that mailbox pending (non-empty) from the next cycle. The engine then sees its fields. A standard frame (`eng_ide`=0) presents only the low 11 identifier bits with the upper bits zero; an extended frame presents all 29 bits.
- R3: A remote frame (`eng_rtr`=1) is presented with `eng_data` all zero, and its length code is passed unchanged.
- R4: Among pending mailboxes that are not in flight, the one with the smallest priority key is offered. The key is the 29-bit identifier for extended frames and the 11-bit identifier shifted left by 18 for standard frames. On equal keys the lowest mailbox index wins.
- R5: Result code 0 (OK) on the in-flight mailbox sets its `done_flag` and `ok_flag`, clears its `err_flag` and `lost_flag`, and empties it on the next cycle.
- R6: With `single_shot`=0, result code 1 (error) or 2 (arbitration lost) leaves the mailbox pending with no completion, and it is offered again. Code 3 is treated as an error.
- R7: With `single_shot`=1, an error or lost result completes the mailbox at once. It sets `done_flag` together with exactly one of `err_flag` (code 1) or `lost_flag` (code 2), and the mailbox becomes empty.
- R8: Writing 1 to a `done_clr` bit clears that mailbox's done, OK, error and lost flags. A completion in the same cycle takes precedence and leaves the new flags set.
- R9: An abort bit on a pending mailbox that is not in flight empties it and sets `done_flag` with all three status flags 0. On the in-flight mailbox the abort is held, including an abort in the accept cycle. An OK result then completes normally, and a failing result completes without retry and carries its status flag.
- R10: Frame writes and `req_set` to a non-empty mailbox are ignored.
- R11: `any_empty` is the OR of `mb_empty`, and `irq` equals `empty_irq_en` AND `any_empty`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| single_shot | input | 1 | One attempt per request, no retry |
| empty_irq_en | input | 1 | Enables the free-mailbox interrupt |
| wr_en | input | 1 | Frame write strobe |
| wr_sel | input | 2 | Target mailbox of the write |
| wr_id | input | 29 | Identifier (standard uses low 11 bits) |
| wr_ide | input | 1 | 1 = extended frame |
| wr_rtr | input | 1 | 1 = remote frame |
| wr_dlc | input | 4 | Length code |
| wr_data | input | 64 | Payload |
| req_set | input | 3 | Per-mailbox transmit request |
| abort_req | input | 3 | Per-mailbox abort |
| done_clr | input | 3 | Write-1-to-clear of completion flags |
| eng_req_valid | output | 1 | A frame is offered to the engine |
| eng_mb_idx | output | 2 | Mailbox being offered |
| eng_id | output | 29 | Offered identifier |
| eng_ide | output | 1 | Offered frame format |
| eng_rtr | output | 1 | Offered remote flag |
| eng_dlc | output | 4 | Offered length code |
| eng_data | output | 64 | Offered payload |
| eng_accept | input | 1 | Engine takes the offered frame |
| res_valid | input | 1 | Engine reports the in-flight result |
| res_code | input | 2 | 0 OK, 1 error, 2 lost, 3 error |
| mb_empty | output | 3 | Per-mailbox free flag |
| any_empty | output | 1 | Some mailbox is free |
| done_flag | output | 3 | Request completed |
| ok_flag | output | 3 | Completed with success |
| err_flag | output | 3 | Completed with error |
| lost_flag | output | 3 | Completed with arbitration lost |
| irq | output | 1 | Free-mailbox interrupt |

## Verification
Two pairs of events can land in the same cycle. In the first, the engine's result arrives in the same cycle as the host's write-1-clear of that mailbox's completion flag. The bench drives both in one cycle and expects the fresh completion flags to survive. In the second, an abort arrives in the same cycle as the engine's accept of that mailbox. The bench drives both together and expects the mailbox to stay in flight with no completion. A following lost result must then finish it with the lost flag and no retry.

// File: rtl/can_txmb_pkg.sv
package can_txmb_pkg;
  localparam int ID_W   = 29;
  localparam int STD_W  = 11;
  localparam int DLC_W  = 4;
  localparam int DATA_W = 64;
  localparam int RES_W  = 2;

  typedef enum logic [RES_W-1:0] {
    RES_OK   = 2'd0,
    RES_ERR  = 2'd1,
    RES_LOST = 2'd2,
    RES_RSVD = 2'd3
  } res_e;

  typedef struct packed {
    logic [ID_W-1:0]   id;
    logic              ide;
    logic              rtr;
    logic [DLC_W-1:0]  dlc;
    logic [DATA_W-1:0] data;
  } frame_t;

  // Priority key: standard identifiers occupy the top bits of the extended space.
  function automatic logic [ID_W-1:0] prio_key(input logic [ID_W-1:0] id, input logic ide);
    return ide ? id : {id[STD_W-1:0], {(ID_W-STD_W){1'b0}}};
  endfunction

  // Frame as the engine sees it: masked identifier, no payload on remote frames.
  function automatic frame_t on_wire(input frame_t f);
    frame_t o;
    o = f;
    if (!f.ide) o.id = {{(ID_W-STD_W){1'b0}}, f.id[STD_W-1:0]};
    if (f.rtr)  o.data = '0;
    return o;
  endfunction
endpackage

// File: rtl/can_txmb_slot.sv
module can_txmb_slot
  import can_txmb_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             single_shot,
  input  logic             load_en,
  input  frame_t           load_frame,
  input  logic             go,
  input  logic             abort,
  input  logic             clr,
  input  logic             accept,
  input  logic             res_valid,
  input  logic [RES_W-1:0] res_code,
  output logic             pending,
  output logic             inflight,
  output frame_t           frame_q,
  output logic             done,
  output logic             ok,
  output logic             err,
  output logic             lost,
  output logic             complete_evt
);
  logic pend_q, fly_q, hold_q, done_q, ok_q, err_q, lost_q;
  logic is_ok, is_lost, is_err, result_here, finish, idle_abort;

  assign is_ok       = (res_code == RES_OK);
  assign is_lost     = (res_code == RES_LOST);
  assign is_err      = !is_ok && !is_lost;
  assign result_here = res_valid && fly_q;
  assign finish      = result_here && (is_ok || single_shot || hold_q || abort);
  assign idle_abort  = abort && pend_q && !fly_q && !accept;
  assign complete_evt = finish || idle_abort;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_q  <= 1'b0;
      fly_q   <= 1'b0;
      hold_q  <= 1'b0;
      done_q  <= 1'b0;
      ok_q    <= 1'b0;
      err_q   <= 1'b0;
      lost_q  <= 1'b0;
      frame_q <= '0;
    end else begin
      if (load_en && !pend_q) frame_q <= load_frame;
      if (go && !pend_q)      pend_q  <= 1'b1;
      if (clr) begin
        done_q <= 1'b0;
        ok_q   <= 1'b0;
        err_q  <= 1'b0;
        lost_q <= 1'b0;
      end
      if (accept && pend_q && !fly_q) begin
        fly_q <= 1'b1;
        if (abort) hold_q <= 1'b1;
      end else if (idle_abort) begin
        pend_q <= 1'b0;
        done_q <= 1'b1;
        ok_q   <= 1'b0;
        err_q  <= 1'b0;
        lost_q <= 1'b0;
      end
      if (abort && fly_q) hold_q <= 1'b1;
      if (result_here) begin
        fly_q  <= 1'b0;
        hold_q <= 1'b0;
        if (finish) begin
          pend_q <= 1'b0;
          done_q <= 1'b1;
          ok_q   <= is_ok;
          err_q  <= is_err;
          lost_q <= is_lost;
        end
      end
    end
  end

  assign pending  = pend_q;
  assign inflight = fly_q;
  assign done     = done_q;
  assign ok       = ok_q;
  assign err      = err_q;
  assign lost     = lost_q;
endmodule

// File: rtl/can_txmb_pick.sv
module can_txmb_pick
  import can_txmb_pkg::*;
#(
  parameter int N = 3,
  localparam int IDX_W = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]    elig,
  input  logic [ID_W-1:0] keys [N],
  output logic            any,
  output logic [IDX_W-1:0] idx
);
  logic [ID_W-1:0] best;

  always_comb begin
    any  = 1'b0;
    idx  = '0;
    best = '0;
    for (int i = 0; i < N; i++) begin
      if (elig[i] && (!any || keys[i] < best)) begin
        any  = 1'b1;
        idx  = IDX_W'(i);
        best = keys[i];
      end
    end
  end
endmodule

// File: rtl/can_txmb_ctrl.sv
module can_txmb_ctrl
  import can_txmb_pkg::*;
#(
  parameter int NUM_MB = 3,
  localparam int IDX_W = (NUM_MB > 1) ? $clog2(NUM_MB) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              single_shot,
  input  logic              empty_irq_en,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_sel,
  input  logic [ID_W-1:0]   wr_id,
  input  logic              wr_ide,
  input  logic              wr_rtr,
  input  logic [DLC_W-1:0]  wr_dlc,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [NUM_MB-1:0] req_set,
  input  logic [NUM_MB-1:0] abort_req,
  input  logic [NUM_MB-1:0] done_clr,
  output logic              eng_req_valid,
  output logic [IDX_W-1:0]  eng_mb_idx,
  output logic [ID_W-1:0]   eng_id,
  output logic              eng_ide,
  output logic              eng_rtr,
  output logic [DLC_W-1:0]  eng_dlc,
  output logic [DATA_W-1:0] eng_data,
  input  logic              eng_accept,
  input  logic              res_valid,
  input  logic [RES_W-1:0]  res_code,
  output logic [NUM_MB-1:0] mb_empty,
  output logic              any_empty,
  output logic [NUM_MB-1:0] done_flag,
  output logic [NUM_MB-1:0] ok_flag,
  output logic [NUM_MB-1:0] err_flag,
  output logic [NUM_MB-1:0] lost_flag,
  output logic              irq
);
  frame_t            wr_frame;
  frame_t            fq [NUM_MB];
  frame_t            shown;
  logic [ID_W-1:0]   keys [NUM_MB];
  logic [NUM_MB-1:0] pend_vec, fly_vec, elig, accept_vec, complete_vec;
  logic              pick_any, busy;
  logic [IDX_W-1:0]  pick_idx, fly_idx;

  assign wr_frame = '{id: wr_id, ide: wr_ide, rtr: wr_rtr, dlc: wr_dlc, data: wr_data};

  for (genvar g = 0; g < NUM_MB; g++) begin : g_mb
    can_txmb_slot u_slot (
      .clk         (clk),
      .rst_n       (rst_n),
      .single_shot (single_shot),
      .load_en     (wr_en && (wr_sel == IDX_W'(g))),
      .load_frame  (wr_frame),
      .go          (req_set[g]),
      .abort       (abort_req[g]),
      .clr         (done_clr[g]),
      .accept      (accept_vec[g]),
      .res_valid   (res_valid),
      .res_code    (res_code),
      .pending     (pend_vec[g]),
      .inflight    (fly_vec[g]),
      .frame_q     (fq[g]),
      .done        (done_flag[g]),
      .ok          (ok_flag[g]),
      .err         (err_flag[g]),
      .lost        (lost_flag[g]),
      .complete_evt(complete_vec[g])
    );
    assign keys[g]       = prio_key(fq[g].id, fq[g].ide);
    assign accept_vec[g] = eng_accept && eng_req_valid && (pick_idx == IDX_W'(g));
  end

  assign busy = |fly_vec;
  assign elig = pend_vec & ~fly_vec;

  can_txmb_pick #(.N(NUM_MB)) u_pick (
    .elig (elig),
    .keys (keys),
    .any  (pick_any),
    .idx  (pick_idx)
  );

  always_comb begin
    fly_idx = '0;
    for (int i = 0; i < NUM_MB; i++)
      if (fly_vec[i]) fly_idx = IDX_W'(i);
  end

  assign shown         = on_wire(fq[pick_idx]);
  assign eng_req_valid = pick_any && !busy;
  assign eng_mb_idx    = pick_idx;
  assign eng_id        = shown.id;
  assign eng_ide       = shown.ide;
  assign eng_rtr       = shown.rtr;
  assign eng_dlc       = shown.dlc;
  assign eng_data      = shown.data;

  assign mb_empty  = ~pend_vec;
  assign any_empty = |mb_empty;
  assign irq       = empty_irq_en && any_empty;
endmodule

// File: rtl/can_txmb_chk.sv
module can_txmb_chk
  import can_txmb_pkg::*;
#(
  parameter int NUM_MB = 3,
  localparam int IDX_W = (NUM_MB > 1) ? $clog2(NUM_MB) : 1
) (
  input logic              clk,
  input logic              rst_n,
  input logic              single_shot,
  input logic              empty_irq_en,
  input logic              eng_req_valid,
  input logic [IDX_W-1:0]  eng_mb_idx,
  input logic              eng_rtr,
  input logic [DATA_W-1:0] eng_data,
  input logic              res_valid,
  input logic [NUM_MB-1:0] mb_empty,
  input logic [NUM_MB-1:0] done_flag,
  input logic [NUM_MB-1:0] ok_flag,
  input logic [NUM_MB-1:0] err_flag,
  input logic [NUM_MB-1:0] lost_flag,
  input logic              irq,
  input logic [NUM_MB-1:0] fly_vec,
  input logic [NUM_MB-1:0] complete_vec,
  input logic [IDX_W-1:0]  fly_idx
);
  for (genvar g = 0; g < NUM_MB; g++) begin : g_chk
    assert_flags_exclusive_R5: assert property (@(posedge clk) disable iff (!rst_n)
      done_flag[g] |-> $onehot0({ok_flag[g], err_flag[g], lost_flag[g]}));
    assert_flags_need_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !done_flag[g] |-> ({ok_flag[g], err_flag[g], lost_flag[g]} == 3'b000));
    assert_complete_frees_R9: assert property (@(posedge clk) disable iff (!rst_n)
      complete_vec[g] |=> (mb_empty[g] && done_flag[g]));
  end

  assert_one_in_flight_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(fly_vec));
  assert_offer_is_pending_R4: assert property (@(posedge clk) disable iff (!rst_n)
    eng_req_valid |-> (!mb_empty[eng_mb_idx] && fly_vec == '0));
  assert_remote_empty_payload_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (eng_req_valid && eng_rtr) |-> (eng_data == '0));
  assert_single_shot_ends_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && single_shot && fly_vec != '0) |=> mb_empty[$past(fly_idx)]);
  assert_irq_follows_free_R11: assert property (@(posedge clk) disable iff (!rst_n)
    irq == (empty_irq_en && (mb_empty != '0)));
endmodule

bind can_txmb_ctrl can_txmb_chk #(.NUM_MB(NUM_MB)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .single_shot  (single_shot),
  .empty_irq_en (empty_irq_en),
  .eng_req_valid(eng_req_valid),
  .eng_mb_idx   (eng_mb_idx),
  .eng_rtr      (eng_rtr),
  .eng_data     (eng_data),
  .res_valid    (res_valid),
  .mb_empty     (mb_empty),
  .done_flag    (done_flag),
  .ok_flag      (ok_flag),
  .err_flag     (err_flag),
  .lost_flag    (lost_flag),
  .irq          (irq),
  .fly_vec      (fly_vec),
  .complete_vec (complete_vec),
  .fly_idx      (fly_idx)
);

// File: tb/can_txmb_ctrl_test.sv
module can_txmb_ctrl_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic single_shot = 1'b0, empty_irq_en = 1'b0;
  logic wr_en = 1'b0;
  logic [1:0] wr_sel = '0;
  logic [28:0] wr_id = '0;
  logic wr_ide = 1'b0, wr_rtr = 1'b0;
  logic [3:0] wr_dlc = '0;
  logic [63:0] wr_data = '0;
  logic [2:0] req_set = '0, abort_req = '0, done_clr = '0;
  logic eng_req_valid;
  logic [1:0] eng_mb_idx;
  logic [28:0] eng_id;
  logic eng_ide, eng_rtr;
  logic [3:0] eng_dlc;
  logic [63:0] eng_data;
  logic eng_accept = 1'b0, res_valid = 1'b0;
  logic [1:0] res_code = '0;
  logic [2:0] mb_empty, done_flag, ok_flag, err_flag, lost_flag;
  logic any_empty, irq;
  int n_run = 0, n_fail = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  can_txmb_ctrl uut (.*);

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic wrap_up();
    if (!finished) begin
      finished = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  endtask

  task automatic load(input int mb, input logic [28:0] id, input logic ide, input logic rtr,
                      input logic [3:0] dlc, input logic [63:0] d, input logic go);
    wr_en = 1'b1; wr_sel = 2'(mb); wr_id = id; wr_ide = ide; wr_rtr = rtr;
    wr_dlc = dlc; wr_data = d; req_set = go ? 3'(1 << mb) : 3'b000;
    @(negedge clk);
    wr_en = 1'b0; req_set = '0;
  endtask

  task automatic take();
    eng_accept = 1'b1; @(negedge clk); eng_accept = 1'b0;
  endtask

  task automatic report(input logic [1:0] code);
    res_valid = 1'b1; res_code = code; @(negedge clk); res_valid = 1'b0;
  endtask

  task automatic abort_mask(input logic [2:0] m);
    abort_req = m; @(negedge clk); abort_req = '0;
  endtask

  task automatic clear_mask(input logic [2:0] m);
    done_clr = m; @(negedge clk); done_clr = '0;
  endtask

  function automatic logic [28:0] key_of(input logic [28:0] id, input logic ide);
    return ide ? id : 29'((id & 29'h7FF) * 29'd262144);
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    wrap_up();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 empty", mb_empty, 3'b111);
    check("R1 any_empty", any_empty, 1);
    check("R1 done", done_flag | ok_flag | err_flag | lost_flag, 0);
    check("R1 valid", eng_req_valid, 0);
    check("R11 irq off", irq, 0);
    empty_irq_en = 1'b1; @(negedge clk);
    check("R11 irq on", irq, 1);

    // R2 standard frame, upper id bits dropped
    load(1, 29'h1ABCD123, 1'b0, 1'b0, 4'd8, 64'h0102030405060708, 1'b1);
    check("R2 empty", mb_empty, 3'b101);
    check("R2 valid", eng_req_valid, 1);
    check("R2 idx", eng_mb_idx, 1);
    check("R2 id", eng_id, 29'h123);
    check("R2 data", eng_data, 64'h0102030405060708);
    check("R2 dlc", eng_dlc, 8);
    // R10 reload of pending mailbox ignored
    load(1, 29'h55, 1'b1, 1'b0, 4'd2, 64'hFF, 1'b1);
    check("R10 id kept", eng_id, 29'h123);
    check("R10 ide kept", eng_ide, 0);
    take();
    check("R6 busy", eng_req_valid, 0);
    report(2'd0);
    check("R5 done", done_flag, 3'b010);
    check("R5 ok", ok_flag, 3'b010);
    check("R5 err lost", err_flag | lost_flag, 0);
    check("R5 empty", mb_empty, 3'b111);
    clear_mask(3'b010);
    check("R8 clear", done_flag | ok_flag, 0);

    // R3 remote extended frame, then R6 retries
    load(0, 29'h1F00_0001, 1'b1, 1'b1, 4'd5, 64'hDEADBEEF, 1'b1);
    check("R3 data zero", eng_data, 0);
    check("R3 dlc", eng_dlc, 5);
    check("R2 ext id", eng_id, 29'h1F00_0001);
    take(); report(2'd1);
    check("R6 err retry done", done_flag, 0);
    check("R6 err retry pending", mb_empty[0], 0);
    check("R6 reoffer", eng_req_valid, 1);
    take(); report(2'd3);
    check("R6 code3 retry", {done_flag[0], mb_empty[0]}, 2'b00);
    take(); report(2'd2);
    check("R6 lost retry", {done_flag[0], mb_empty[0]}, 2'b00);
    take(); report(2'd0);
    check("R5 after retries", {done_flag[0], ok_flag[0], mb_empty[0]}, 3'b111);
    clear_mask(3'b001);

    // R7 single shot
    single_shot = 1'b1;
    load(2, 29'h10, 1'b0, 1'b0, 4'd1, 64'h1, 1'b1);
    take(); report(2'd1);
    check("R7 err", {done_flag[2], ok_flag[2], err_flag[2], lost_flag[2], mb_empty[2]}, 5'b10101);
    clear_mask(3'b100);
    load(2, 29'h10, 1'b0, 1'b0, 4'd1, 64'h1, 1'b1);
    take(); report(2'd2);
    check("R7 lost", {done_flag[2], ok_flag[2], err_flag[2], lost_flag[2], mb_empty[2]}, 5'b10011);
    clear_mask(3'b100);
    single_shot = 1'b0;

    // R9 abort idle mailbox and in-flight mailbox
    load(0, 29'h5, 1'b0, 1'b0, 4'd0, 64'h0, 1'b1);
    load(1, 29'h9, 1'b0, 1'b0, 4'd0, 64'h0, 1'b1);
    check("R4 lower id", eng_mb_idx, 0);
    abort_mask(3'b010);
    check("R9 idle abort", {done_flag[1], ok_flag[1], err_flag[1], lost_flag[1], mb_empty[1]}, 5'b10001);
    take();
    abort_mask(3'b001);
    check("R9 held", {done_flag[0], mb_empty[0]}, 2'b00);
    report(2'd1);
    check("R9 fly abort", {done_flag[0], err_flag[0], mb_empty[0]}, 3'b111);
    clear_mask(3'b011);

    // R8 completion and clear in the same cycle
    load(2, 29'h7, 1'b1, 1'b0, 4'd3, 64'h3, 1'b1);
    take();
    done_clr = 3'b100; res_valid = 1'b1; res_code = 2'd0;
    @(negedge clk);
    done_clr = '0; res_valid = 1'b0;
    check("R8 completion wins", {done_flag[2], ok_flag[2]}, 2'b11);
    clear_mask(3'b100);
    // R9 abort in the accept cycle
    load(0, 29'h7, 1'b1, 1'b0, 4'd3, 64'h3, 1'b1);
    eng_accept = 1'b1; abort_req = 3'b001;
    @(negedge clk);
    eng_accept = 1'b0; abort_req = '0;
    check("R9 accept+abort in flight", {done_flag[0], mb_empty[0], eng_req_valid}, 3'b000);
    report(2'd2);
    check("R9 accept+abort lost", {done_flag[0], lost_flag[0], mb_empty[0]}, 3'b111);
    clear_mask(3'b001);

    // R4 sweep over frame formats and identifier patterns
    for (int pat = 0; pat < 8; pat++) begin
      for (int s = 0; s < 4; s++) begin
        logic [28:0] ids [3];
        logic [28:0] best;
        int win;
        for (int i = 0; i < 3; i++) begin
          logic [28:0] v;
          v = 29'((s + 2 * i) % 3);
          ids[i] = pat[i] ? 29'((v * 29'd262144) + ((s & 1) != 0 ? i : 0)) : v;
          load(i, ids[i], pat[i], 1'b0, 4'd0, 64'h0, 1'b1);
        end
        win = 0; best = key_of(ids[0], pat[0]);
        for (int i = 1; i < 3; i++)
          if (key_of(ids[i], pat[i]) < best) begin
            win = i; best = key_of(ids[i], pat[i]);
          end
        check("R4 sweep idx", eng_mb_idx, 64'(win));
        check("R4 sweep id", eng_id, pat[win] ? ids[win] : (ids[win] & 29'h7FF));
        abort_mask(3'b111);
        check("R11 all free", {any_empty, irq}, 2'b11);
        clear_mask(3'b111);
      end
    end
    wrap_up();
  end
endmodule